// File: doc/BRIEF.md
# State-Change Triggered Burst Sequencer

This block runs on a fast clock and watches the state code of a separate, slower state machine that lives in another clock domain. The slow code is brought across through a chain of synchronizing registers. Each time the synchronized code differs from the value held one fast cycle earlier, the sequencer runs one complete pass through a fixed series of active states, one per fast clock, and then returns to its wait state.

A change that arrives while a pass is already running is not lost. It sets a pending flag, and that flag starts one more pass as soon as the running pass has gone back to wait. Any number of changes seen during one pass merge into that single extra pass. The design uses only the fast clock. It needs no per-signal event detection and no derived clocks. Downstream logic decodes the sequencer state to drive its own datapath.

Top module: `trig_burst_seq`

## Requirements
- R1: While reset is low, and afterwards, the state output is 0 (wait), busy is low and done is low. If the slow code equals the reset code (`RESET_CODE`, default 3'b000), no pass starts after reset is released.
- R2: A code change that is applied between two fast edges shows the sequencer in state 1 after the third following rising edge, and still in state 0 after the second.
- R3: A pass visits states 1, 2, 3, 4 and 5 (`N_ACTIVE`) on consecutive fast cycles and then returns to state 0.
- R4: Busy is high exactly when the state output is non-zero.
- R5: Done is high for exactly one fast cycle. That cycle is the first cycle in state 0 after state 5, and done is never high at any other time.
- R6: Writing the same code again, or holding the code steady, starts no pass.
- R7: A change that is detected during a pass, including during state 5, starts one more pass. That pass enters state 1 one cycle after the return to wait.
- R8: Two or more changes detected during the same pass give exactly one extra pass in total.
- R9: A change that is detected in the wait cycle that follows a pass starts a new pass on the next edge.
- R10: Asserting reset during a pass forces state 0 at once and discards any pending pass. After release, with the input at the reset code, no pass runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_code_i | input | CODE_W (3) | Gray-coded state of the slow machine, asynchronous to clk_i |
| seq_state_o | output | $clog2(N_ACTIVE+1) (3) | Sequencer state: 0 = wait, 1..N_ACTIVE = active steps |
| busy_o | output | 1 | High while an active step is being shown |
| done_o | output | 1 | One-cycle pulse on the return from the last step to wait |

## Verification
The bench builds the block with its defaults: a 3-bit code, two synchronizer stages, five active steps and a reset code of zero. These values keep a whole pass to eight cycles from the input change to the done pulse. That makes it possible to place second and third changes at chosen offsets into a pass: in an early step, in the last step, and in the done cycle itself. Each of those placements gives a known count of passes, either merged or separate.

// File: rtl/trig_burst_seq_pkg.sv
package trig_burst_seq_pkg;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_ACTIVE      = 2;

   // bits needed to encode the wait state plus n_active active steps
   function automatic int unsigned state_bits(input int unsigned n_active);
      return $clog2(n_active + 1);
   endfunction

endpackage

// File: rtl/trig_burst_seq_sync.sv
module trig_burst_seq_sync #(
   parameter int unsigned           W       = 3,
   parameter int unsigned           STAGES  = 2,
   parameter logic [W-1:0]          RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   localparam int unsigned CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain_q;

   // every stage of the chain resets to the slow machine's reset code
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[CHAIN_W-W-1:0], din_i};
      end
   end

   assign dout_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/trig_burst_seq_chgdet.sv
module trig_burst_seq_chgdet #(
   parameter int unsigned  W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] code_i,
   output logic         chg_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= RST_VAL;
      else         prev_q <= code_i;
   end

   assign chg_o = (prev_q != code_i);
endmodule

// File: rtl/trig_burst_seq_core.sv
module trig_burst_seq_core #(
   parameter int unsigned N_ACTIVE = 5,
   parameter int unsigned SW       = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          chg_i,
   output logic [SW-1:0] state_o,
   output logic          pend_o,
   output logic          done_o
);
   localparam logic [SW-1:0] ST_WAIT = '0;
   localparam logic [SW-1:0] ST_LAST = SW'(N_ACTIVE);

   logic [SW-1:0] st_q;
   logic          pend_q;
   logic          done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_WAIT;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= (st_q == ST_LAST);
         if (st_q == ST_WAIT) begin
            // a fresh change and a queued one both start the same pass
            if (chg_i || pend_q) st_q <= SW'(1);
            pend_q <= 1'b0;
         end else begin
            if (chg_i) pend_q <= 1'b1;
            st_q <= (st_q == ST_LAST) ? ST_WAIT : st_q + SW'(1);
         end
      end
   end

   assign state_o = st_q;
   assign pend_o  = pend_q;
   assign done_o  = done_q;
endmodule

// File: rtl/trig_burst_seq.sv
module trig_burst_seq #(
   parameter int unsigned           CODE_W      = 3,
   parameter int unsigned           SYNC_STAGES = 2,
   parameter int unsigned           N_ACTIVE    = 5,
   parameter logic [CODE_W-1:0]     RESET_CODE  = '0,
   localparam int unsigned          SW          = trig_burst_seq_pkg::state_bits(N_ACTIVE)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] slow_code_i,
   output logic [SW-1:0]     seq_state_o,
   output logic              busy_o,
   output logic              done_o
);
   // elaboration-time parameter checks
   if (SYNC_STAGES < trig_burst_seq_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("trig_burst_seq: SYNC_STAGES must be at least 2");
   end
   if (N_ACTIVE < trig_burst_seq_pkg::MIN_ACTIVE) begin : g_bad_active
      $error("trig_burst_seq: N_ACTIVE must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("trig_burst_seq: CODE_W must be at least 1");
   end

   logic [CODE_W-1:0] code_sync;
   logic              chg;
   logic              pend;

   trig_burst_seq_sync #(
      .W       (CODE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (RESET_CODE)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (slow_code_i),
      .dout_o (code_sync)
   );

   trig_burst_seq_chgdet #(
      .W       (CODE_W),
      .RST_VAL (RESET_CODE)
   ) u_chgdet (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (code_sync),
      .chg_o  (chg)
   );

   trig_burst_seq_core #(
      .N_ACTIVE (N_ACTIVE),
      .SW       (SW)
   ) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .chg_i   (chg),
      .state_o (seq_state_o),
      .pend_o  (pend),
      .done_o  (done_o)
   );

   assign busy_o = (seq_state_o != '0);
endmodule

// File: rtl/trig_burst_seq_chk.sv
module trig_burst_seq_chk #(
   parameter int unsigned N_ACTIVE = 5,
   parameter int unsigned SW       = 3
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [SW-1:0] st_i,
   input logic          busy_i,
   input logic          done_i,
   input logic          chg_i,
   input logic          pend_i
);
   localparam logic [SW-1:0] LAST = SW'(N_ACTIVE);

   p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i != '0 && st_i != LAST) |=> st_i == SW'($past(st_i) + SW'(1)));

   p_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i == LAST) |=> st_i == '0);

   p_done_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i == LAST) |=> done_i);

   p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> !busy_i);

   p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i == '0 && !chg_i && !pend_i) |=> st_i == '0);

   p_pend_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i == '0 && pend_i) |=> st_i == SW'(1));

   p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i != '0 && chg_i) |=> pend_i);
endmodule

bind trig_burst_seq trig_burst_seq_chk #(
   .N_ACTIVE (N_ACTIVE),
   .SW       (SW)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .st_i   (seq_state_o),
   .busy_i (busy_o),
   .done_i (done_o),
   .chg_i  (chg),
   .pend_i (pend)
);

// File: tb/trig_burst_seq_tb.sv
`timescale 1ns/1ps
module trig_burst_seq_tb;
   localparam int  LAST  = 5;
   localparam int  NV    = 11;
   localparam real HALF  = 2.5;
   localparam int  LIMIT = 200000;

   // fields: c0[17:15] c1[14:12] c2[11:9] n_changes[8:7] gap[6:2] expected_passes[1:0]
   localparam logic [17:0] VEC [NV] = '{
      {3'b011, 3'b000, 3'b000, 2'd1, 5'd0,  2'd1},  // R3 single change
      {3'b011, 3'b000, 3'b000, 2'd1, 5'd0,  2'd0},  // R6 same code
      {3'b010, 3'b110, 3'b000, 2'd2, 5'd1,  2'd2},  // R7 early in pass
      {3'b010, 3'b000, 3'b000, 2'd2, 5'd15, 2'd2},  // separate passes
      {3'b001, 3'b011, 3'b010, 2'd3, 5'd2,  2'd2},  // R8 merge
      {3'b110, 3'b010, 3'b000, 2'd2, 5'd1,  2'd2},  // R7 toggle back
      {3'b010, 3'b000, 3'b000, 2'd1, 5'd0,  2'd0},  // R6 same code
      {3'b000, 3'b001, 3'b011, 2'd3, 5'd3,  2'd2},  // R8 / R9 mix
      {3'b010, 3'b110, 3'b000, 2'd2, 5'd5,  2'd2},  // R7 in last step
      {3'b010, 3'b011, 3'b000, 2'd2, 5'd6,  2'd2},  // R9 in done cycle
      {3'b001, 3'b000, 3'b000, 2'd1, 5'd0,  2'd1}   // R3 single change
   };

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] code = 3'b000;
   logic [2:0] st;
   logic       busy;
   logic       done;

   int n_chk  = 0;
   int n_fail = 0;
   int bursts = 0;
   int dones  = 0;
   int prev_st = 0;
   bit finished = 1'b0;

   always #(HALF) clk = ~clk;

   trig_burst_seq u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .slow_code_i (code),
      .seq_state_o (st),
      .busy_o      (busy),
      .done_o      (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic set_code(input logic [2:0] c, input real ph);
      @(posedge clk);
      #(ph);
      code = c;
   endtask

   // sequence monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (!rst_ni) begin
         prev_st = 0;
      end else begin
         if (int'(st) == 1) bursts++;
         if (done) dones++;
         if (st != 3'd0 || prev_st != 0) begin
            if (prev_st == 0)
               chk(int'(st) == 1, "R3 entry", int'(st), 1);
            else if (prev_st == LAST) begin
               chk(st == 3'd0, "R3 return", int'(st), 0);
               chk(done == 1'b1, "R5 done on return", int'(done), 1);
            end else
               chk(int'(st) == prev_st + 1, "R3 step", int'(st), prev_st + 1);
            chk(busy == (st != 3'd0), "R4 busy", int'(busy), int'(st != 3'd0));
         end
         if (done && prev_st != LAST)
            chk(1'b0, "R5 stray done", 1, 0);
         prev_st = int'(st);
      end
   end

   initial begin
      #(LIMIT * 2.0 * HALF);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int b0;
      int d0;
      logic [17:0] v;
      real ph;
      int g;

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(st == 3'd0, "R1 state in reset", int'(st), 0);
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      chk(done == 1'b0, "R1 done in reset", int'(done), 0);
      @(negedge clk);
      rst_ni = 1'b1;
      settle(10);
      chk(bursts == 0, "R1 no pass after reset", bursts, 0);
      chk(st == 3'd0, "R1 wait after reset", int'(st), 0);

      // R2: latency, then R3/R5 timing of one pass
      code = 3'b001;
      @(posedge clk); @(posedge clk); @(negedge clk); #1;
      chk(st == 3'd0, "R2 still waiting", int'(st), 0);
      @(posedge clk); @(negedge clk); #1;
      chk(int'(st) == 1, "R2 pass begins", int'(st), 1);
      settle(4);
      chk(int'(st) == LAST, "R3 last step", int'(st), LAST);
      settle(1);
      chk(st == 3'd0 && done, "R5 done pulse", int'(done), 1);
      settle(1);
      chk(!done, "R5 done one cycle", int'(done), 0);
      settle(20);

      // table of change patterns
      for (int i = 0; i < NV; i++) begin
         v  = VEC[i];
         ph = 0.6 + (i % 4) * 1.1;
         g  = int'(v[6:2]);
         b0 = bursts;
         d0 = dones;
         set_code(v[17:15], ph);
         if (v[8:7] >= 2'd2) begin
            repeat (g - 1) @(posedge clk);
            set_code(v[14:12], ph);
         end
         if (v[8:7] == 2'd3) begin
            repeat (g - 1) @(posedge clk);
            set_code(v[11:9], ph);
         end
         settle(30);
         chk(bursts - b0 == int'(v[1:0]), $sformatf("R7 R8 R9 R6 pass count vector %0d", i),
             bursts - b0, int'(v[1:0]));
         chk(dones - d0 == int'(v[1:0]), $sformatf("R5 done count vector %0d", i),
             dones - d0, int'(v[1:0]));
         chk(!busy, "R4 idle after vector", int'(busy), 0);
      end

      // R10: reset in the middle of a pass with a change pending
      set_code(3'b000, 1.3);
      repeat (3) @(posedge clk);
      set_code(3'b001, 1.3);
      set_code(3'b000, 1.3);
      @(posedge clk);
      @(negedge clk);
      chk(st != 3'd0, "R10 pass running", int'(st), 4);
      rst_ni = 1'b0;
      #1;
      chk(st == 3'd0, "R10 async clear", int'(st), 0);
      chk(!busy, "R10 busy cleared", int'(busy), 0);
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      b0 = bursts;
      settle(20);
      chk(bursts == b0, "R10 pending discarded", bursts - b0, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule